// File: doc/BRIEF.md
# Frame Scanout Address Sequencer

This block turns a programmed memory window into a stream of burst read requests that feed a pixel FIFO ahead of a display output stage. The window is given as a first byte address and an inclusive last byte address, supplied together as a single 64-bit word so the two halves always move as one. In the normal data mode the sequencer walks the window burst by burst, flags the end of each pass and starts again from the first address. In the table mode it fetches a fixed 32-byte colour table from the first address, flags completion and parks.

A new window written while a frame is being fetched is kept in a shadow copy. It becomes the live window only at the next frame boundary, so a frame is never fetched from a half-old, half-new window. Clearing the run enable lets the current frame finish, after which a stop event is raised and no further frame begins. Requests respect the free space in the FIFO, and a small monitor reports when the FIFO has filled to a programmable level and when the output side asked for a pixel from an empty FIFO.

Top module: `scan_fetch_seq`

## Requirements
- R1: After reset, `rd_req_valid`, every event output, `fill_ok` and `bad_burst_cfg` are 0.
- R2: In data mode (`table_mode`=0) requests start at the window's first address, each carries the burst length in 4-byte words, and each next address is the previous one plus 4 times the previous length. The final burst of a pass is shortened so that it ends exactly on the inclusive last byte.
- R3: `burst_sel` codes 0, 1, 2, 3, 4 select bursts of 1, 2, 4, 8, 16 words. Codes 5 to 7 set `bad_burst_cfg` to 1 one cycle later, and no frame is started while such a code is present.
- R4: When the last burst of a data pass is accepted, `ev_frame_end` pulses for one cycle. If `run_en` is still 1 the next pass begins at the first address of the window.
- R5: `win_wr` loads both halves of `win_pair` (last byte in bits 63:32, first byte in bits 31:0) in one cycle into a shadow copy. A pair written during a frame has no effect on that frame's requests and is used from the next frame on.
- R6: In table mode the block fetches 32 bytes (8 words) from the first address, ignoring the last-byte half. It then pulses `ev_table_done` once, never pulses `ev_frame_end`, and issues no further requests while `run_en` stays 1.
- R7: When `run_en` is cleared during a data frame, that frame is fetched to its end. `ev_stopped` pulses together with its `ev_frame_end`, and no request follows.
- R8: A request is raised only when the FIFO free space (`FIFO_DEPTH` minus `fifo_level`) is at least the length of that burst.
- R9: While `rd_req_valid` is 1 and `rd_req_ready` is 0, the request stays valid with unchanged address and length.
- R10: While a fetch is active, `fill_ok` becomes 1 the cycle after `fifo_level` first reaches `fill_mark`, and stays 1 until the block is idle again.
- R11: `ev_underrun` pulses one cycle after a cycle in which `pix_pull` is 1 and `fifo_level` is 0, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_wr | input | 1 | Load `win_pair` into the shadow window |
| win_pair | input | 64 | Last byte address [63:32], first byte address [31:0] |
| table_mode | input | 1 | 1 selects the 32-byte table fetch, 0 the frame data fetch |
| burst_sel | input | 3 | Burst length code |
| fill_mark | input | LVL_W | FIFO level at which output may begin |
| run_en | input | 1 | Run enable |
| fifo_level | input | LVL_W | Words held or reserved in the pixel FIFO |
| pix_pull | input | 1 | Output side wants a pixel this cycle |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_valid | output | 1 | Request valid |
| rd_req_addr | output | 32 | Request byte address |
| rd_req_len | output | 5 | Request length in words |
| ev_frame_end | output | 1 | One data pass finished |
| ev_table_done | output | 1 | Table fetch finished |
| ev_stopped | output | 1 | Fetch stopped after run enable cleared |
| ev_underrun | output | 1 | Pixel requested from an empty FIFO |
| fill_ok | output | 1 | FIFO has reached `fill_mark` |
| bad_burst_cfg | output | 1 | Burst code not supported |

## Verification
The data walk is driven with a 10-word window and 4-word bursts, which separates a correct clipped last burst from overrun or truncation. Then a second window is written mid-frame, which shows whether the swap waits for the boundary. A 64-word window with 8-word bursts and a stalled memory side tells apart holding a request from dropping it, and a nearly full FIFO shows whether room is checked before issue. The table fetch with 2-word bursts and an oversized last-byte half distinguishes a fixed 32-byte fetch from one that follows the window, and unsupported codes, run-enable removal and empty-FIFO pulls cover the remaining event paths.

// File: rtl/scan_fetch_pkg.sv
package scan_fetch_pkg;

    localparam int SF_ADDR_W = 32;
    localparam int SF_LEN_W  = 5;

    typedef enum logic [1:0] {
        SF_IDLE,
        SF_DATA,
        SF_TABLE,
        SF_PARK
    } sf_state_e;

    // Upper half is the inclusive last byte, lower half the first byte.
    typedef struct packed {
        logic [SF_ADDR_W-1:0] last_b;
        logic [SF_ADDR_W-1:0] first_b;
    } sf_window_t;

    typedef struct packed {
        logic                ok;
        logic [SF_LEN_W-1:0] words;
    } sf_burst_t;

    function automatic sf_burst_t sf_decode_burst(input logic [2:0] code);
        sf_burst_t b;
        b.ok = 1'b1;
        case (code)
            3'd0:    b.words = SF_LEN_W'(1);
            3'd1:    b.words = SF_LEN_W'(2);
            3'd2:    b.words = SF_LEN_W'(4);
            3'd3:    b.words = SF_LEN_W'(8);
            3'd4:    b.words = SF_LEN_W'(16);
            default: begin
                b.ok    = 1'b0;
                b.words = '0;
            end
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sf_window_regs.sv
module sf_window_regs
    import scan_fetch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  sf_window_t wr_pair,
    input  logic       take,
    output sf_window_t shadow,
    output sf_window_t live
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            live   <= '0;
        end else begin
            if (wr_en)
                shadow <= wr_pair;
            if (take)
                live <= shadow;
        end
    end

endmodule

// File: rtl/sf_burst_gen.sv
module sf_burst_gen
    import scan_fetch_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int LVL_W      = 6,
    parameter int TABLE_B    = 32,
    parameter int WORD_B     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run_en,
    input  logic                 table_sel,
    input  sf_burst_t            burst,
    input  logic [LVL_W-1:0]     fifo_level,
    input  sf_window_t           shadow,
    input  sf_window_t           live,
    input  logic                 req_ready,
    output logic                 req_valid,
    output logic [SF_ADDR_W-1:0] req_addr,
    output logic [SF_LEN_W-1:0]  req_len,
    output logic                 take_window,
    output logic                 ev_end,
    output logic                 ev_table,
    output logic                 ev_stop,
    output logic                 busy
);

    localparam int WB_SH  = $clog2(WORD_B);
    localparam int ROOM_W = LVL_W + 1;

    sf_state_e            state_q;
    logic [SF_ADDR_W-1:0] addr_q;
    logic [SF_LEN_W-1:0]  blen_q;
    logic                 last_q;

    logic [SF_ADDR_W-1:0] stop_b;
    logic [SF_ADDR_W-1:0] rem_words;
    logic                 is_last;
    logic [SF_LEN_W-1:0]  cur_len;
    logic [ROOM_W-1:0]    room;
    logic                 fits;
    logic                 start;
    logic                 accept;
    logic                 fetching;

    always_comb begin
        stop_b    = (state_q == SF_TABLE) ? live.first_b + SF_ADDR_W'(TABLE_B - 1)
                                          : live.last_b;
        rem_words = ((stop_b - addr_q) >> WB_SH) + SF_ADDR_W'(1);
        is_last   = rem_words <= SF_ADDR_W'(blen_q);
        cur_len   = is_last ? rem_words[SF_LEN_W-1:0] : blen_q;
        room      = ROOM_W'(FIFO_DEPTH) - ROOM_W'(fifo_level);
        fits      = room >= ROOM_W'(cur_len);
        fetching  = (state_q == SF_DATA) || (state_q == SF_TABLE);
        start     = (state_q == SF_IDLE) && run_en && burst.ok;
        accept    = req_valid && req_ready;
        take_window = start ||
                      (accept && last_q && (state_q == SF_DATA) && run_en);
    end

    assign busy = (state_q != SF_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SF_IDLE;
            addr_q    <= '0;
            blen_q    <= '0;
            last_q    <= 1'b0;
            req_valid <= 1'b0;
            req_addr  <= '0;
            req_len   <= '0;
            ev_end    <= 1'b0;
            ev_table  <= 1'b0;
            ev_stop   <= 1'b0;
        end else begin
            ev_end   <= 1'b0;
            ev_table <= 1'b0;
            ev_stop  <= 1'b0;
            case (state_q)
                SF_IDLE: begin
                    if (start) begin
                        state_q <= table_sel ? SF_TABLE : SF_DATA;
                        blen_q  <= burst.words;
                        addr_q  <= shadow.first_b;
                    end
                end
                SF_PARK: begin
                    if (!run_en)
                        state_q <= SF_IDLE;
                end
                default: begin
                    if (fetching && !req_valid && fits) begin
                        req_valid <= 1'b1;
                        req_addr  <= addr_q;
                        req_len   <= cur_len;
                        last_q    <= is_last;
                        addr_q    <= addr_q + (SF_ADDR_W'(cur_len) << WB_SH);
                    end
                    if (accept) begin
                        req_valid <= 1'b0;
                        if (last_q) begin
                            if (state_q == SF_TABLE) begin
                                ev_table <= 1'b1;
                                state_q  <= SF_PARK;
                            end else begin
                                ev_end <= 1'b1;
                                if (run_en) begin
                                    addr_q <= shadow.first_b;
                                end else begin
                                    ev_stop <= 1'b1;
                                    state_q <= SF_IDLE;
                                end
                            end
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/sf_fifo_watch.sv
module sf_fifo_watch #(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] mark,
    input  logic             pull,
    output logic             fill_ok,
    output logic             underrun
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_ok  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (!busy)
                fill_ok <= 1'b0;
            else if (fifo_level >= mark)
                fill_ok <= 1'b1;
            underrun <= pull && (fifo_level == '0);
        end
    end

endmodule

// File: rtl/scan_fetch_seq.sv
module scan_fetch_seq
    import scan_fetch_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int LVL_W      = $clog2(FIFO_DEPTH) + 1,
    parameter int TABLE_B    = 32,
    parameter int WORD_B     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 win_wr,
    input  logic [63:0]          win_pair,
    input  logic                 table_mode,
    input  logic [2:0]           burst_sel,
    input  logic [LVL_W-1:0]     fill_mark,
    input  logic                 run_en,
    input  logic [LVL_W-1:0]     fifo_level,
    input  logic                 pix_pull,
    input  logic                 rd_req_ready,
    output logic                 rd_req_valid,
    output logic [SF_ADDR_W-1:0] rd_req_addr,
    output logic [SF_LEN_W-1:0]  rd_req_len,
    output logic                 ev_frame_end,
    output logic                 ev_table_done,
    output logic                 ev_stopped,
    output logic                 ev_underrun,
    output logic                 fill_ok,
    output logic                 bad_burst_cfg
);

    sf_window_t shadow_w;
    sf_window_t live_w;
    sf_burst_t  burst_w;
    logic       take_w;
    logic       busy_w;

    assign burst_w = sf_decode_burst(burst_sel);

    always_ff @(posedge clk) begin
        if (rst)
            bad_burst_cfg <= 1'b0;
        else
            bad_burst_cfg <= !burst_w.ok;
    end

    sf_window_regs u_win (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (win_wr),
        .wr_pair (sf_window_t'(win_pair)),
        .take    (take_w),
        .shadow  (shadow_w),
        .live    (live_w)
    );

    sf_burst_gen #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .LVL_W      (LVL_W),
        .TABLE_B    (TABLE_B),
        .WORD_B     (WORD_B)
    ) u_gen (
        .clk         (clk),
        .rst         (rst),
        .run_en      (run_en),
        .table_sel   (table_mode),
        .burst       (burst_w),
        .fifo_level  (fifo_level),
        .shadow      (shadow_w),
        .live        (live_w),
        .req_ready   (rd_req_ready),
        .req_valid   (rd_req_valid),
        .req_addr    (rd_req_addr),
        .req_len     (rd_req_len),
        .take_window (take_w),
        .ev_end      (ev_frame_end),
        .ev_table    (ev_table_done),
        .ev_stop     (ev_stopped),
        .busy        (busy_w)
    );

    sf_fifo_watch #(
        .LVL_W (LVL_W)
    ) u_watch (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy_w),
        .fifo_level (fifo_level),
        .mark       (fill_mark),
        .pull       (pix_pull),
        .fill_ok    (fill_ok),
        .underrun   (ev_underrun)
    );

endmodule

// File: rtl/scan_fetch_chk.sv
module scan_fetch_chk #(
    parameter int FIFO_DEPTH = 32,
    parameter int LVL_W      = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_req_valid,
    input logic             rd_req_ready,
    input logic [31:0]      rd_req_addr,
    input logic [4:0]       rd_req_len,
    input logic [LVL_W-1:0] fifo_level,
    input logic             pix_pull,
    input logic [2:0]       burst_sel,
    input logic             ev_frame_end,
    input logic             ev_table_done,
    input logic             ev_stopped,
    input logic             ev_underrun,
    input logic             bad_burst_cfg
);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=>
            rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len));

    // R8
    room_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_req_valid) |->
            (FIFO_DEPTH - int'($past(fifo_level))) >= int'(rd_req_len));

    // R2
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> (rd_req_len != 5'd0) && (rd_req_len <= 5'd16));

    // R6
    table_no_end_chk: assert property (@(posedge clk) disable iff (rst)
        ev_table_done |-> !ev_frame_end);

    // R7
    stop_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        ev_stopped |-> ev_frame_end);

    // R11
    underrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ev_underrun |-> $past(pix_pull) && ($past(fifo_level) == '0));

    // R3
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        bad_burst_cfg |-> $past(burst_sel) > 3'd4);

endmodule

bind scan_fetch_seq scan_fetch_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .LVL_W      (LVL_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rd_req_valid  (rd_req_valid),
    .rd_req_ready  (rd_req_ready),
    .rd_req_addr   (rd_req_addr),
    .rd_req_len    (rd_req_len),
    .fifo_level    (fifo_level),
    .pix_pull      (pix_pull),
    .burst_sel     (burst_sel),
    .ev_frame_end  (ev_frame_end),
    .ev_table_done (ev_table_done),
    .ev_stopped    (ev_stopped),
    .ev_underrun   (ev_underrun),
    .bad_burst_cfg (bad_burst_cfg)
);

// File: tb/scan_fetch_seq_tb.sv
`timescale 1ns/1ps
module scan_fetch_seq_tb;

    localparam int DEPTH = 32;
    localparam int LW    = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          win_wr = 1'b0;
    logic [63:0]   win_pair = '0;
    logic          table_mode = 1'b0;
    logic [2:0]    burst_sel = 3'd2;
    logic [LW-1:0] fill_mark = '0;
    logic          run_en = 1'b0;
    logic [LW-1:0] fifo_level = '0;
    logic          pix_pull = 1'b0;
    logic          rd_req_ready = 1'b1;
    logic          rd_req_valid;
    logic [31:0]   rd_req_addr;
    logic [4:0]    rd_req_len;
    logic          ev_frame_end, ev_table_done, ev_stopped, ev_underrun;
    logic          fill_ok, bad_burst_cfg;

    always #2 clk = ~clk;

    scan_fetch_seq #(.FIFO_DEPTH(DEPTH), .LVL_W(LW)) u_dut (
        .clk(clk), .rst(rst), .win_wr(win_wr), .win_pair(win_pair),
        .table_mode(table_mode), .burst_sel(burst_sel), .fill_mark(fill_mark),
        .run_en(run_en), .fifo_level(fifo_level), .pix_pull(pix_pull),
        .rd_req_ready(rd_req_ready), .rd_req_valid(rd_req_valid),
        .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
        .ev_frame_end(ev_frame_end), .ev_table_done(ev_table_done),
        .ev_stopped(ev_stopped), .ev_underrun(ev_underrun),
        .fill_ok(fill_ok), .bad_burst_cfg(bad_burst_cfg)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] log_addr [0:63];
    logic [4:0]  log_len  [0:63];
    int n_req = 0, n_end = 0, n_tab = 0, n_stop = 0, n_und = 0;
    bit clr = 0;

    always @(negedge clk) begin
        if (clr) begin
            n_req = 0; n_end = 0; n_tab = 0; n_stop = 0; n_und = 0;
        end else begin
            if (rd_req_valid && rd_req_ready && n_req < 64) begin
                log_addr[n_req] = rd_req_addr;
                log_len[n_req]  = rd_req_len;
                n_req = n_req + 1;
            end
            n_end  = n_end  + int'(ev_frame_end);
            n_tab  = n_tab  + int'(ev_table_done);
            n_stop = n_stop + int'(ev_stopped);
            n_und  = n_und  + int'(ev_underrun);
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic clear_stats();
        @(posedge clk); #1; clr = 1;
        @(posedge clk); #1; clr = 0;
    endtask

    task automatic write_win(input logic [31:0] first_b, input logic [31:0] last_b);
        win_pair = {last_b, first_b};
        win_wr = 1'b1;
        step(1);
        win_wr = 1'b0;
    endtask

    task automatic wait_ends(input int target);
        for (int i = 0; i < 400 && n_end < target; i++) step(1);
    endtask

    task automatic t_reset();
        step(5);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid", rd_req_valid, 0);
        chk("R1 events", {ev_frame_end, ev_table_done, ev_stopped, ev_underrun}, 0);
        chk("R1 fill_ok/bad", {fill_ok, bad_burst_cfg}, 0);
        step(1);
    endtask

    task automatic t_data_walk();
        write_win(32'h100, 32'h127);
        burst_sel = 3'd2; fifo_level = '0; rd_req_ready = 1'b1; table_mode = 1'b0;
        clear_stats();
        run_en = 1'b1;
        wait_ends(1);
        chk("R2 count", n_req, 3);
        chk("R2 a0", log_addr[0], 32'h100); chk("R2 l0", log_len[0], 4);
        chk("R2 a1", log_addr[1], 32'h110); chk("R2 l1", log_len[1], 4);
        chk("R2 a2", log_addr[2], 32'h120); chk("R2 clipped", log_len[2], 2);
        write_win(32'h400, 32'h41F);
        wait_ends(2);
        chk("R4 restart", log_addr[3], 32'h100);
        chk("R5 old window kept", n_req, 6);
        chk("R5 old last", log_addr[5], 32'h120);
        wait_ends(3);
        chk("R5 new a", log_addr[6], 32'h400); chk("R5 new l", log_len[6], 4);
        chk("R5 new a2", log_addr[7], 32'h410);
        chk("R5 new count", n_req, 8);
        run_en = 1'b0;
        for (int i = 0; i < 200 && n_stop < 1; i++) step(1);
        step(40);
        chk("R7 finished frame", n_req, 10);
        chk("R7 last addr", log_addr[9], 32'h410);
        chk("R7 stop count", n_stop, 1);
        chk("R7 end count", n_end, 4);
        @(negedge clk);
        chk("R7 idle", rd_req_valid, 0);
    endtask

    task automatic t_stall_room();
        write_win(32'h800, 32'h8FF);
        burst_sel = 3'd3; fill_mark = LW'(8); fifo_level = LW'(5);
        rd_req_ready = 1'b0;
        clear_stats();
        run_en = 1'b1;
        step(10);
        @(negedge clk);
        chk("R9 valid", rd_req_valid, 1);
        chk("R10 below mark", fill_ok, 0);
        step(10);
        @(negedge clk);
        chk("R9 held addr", rd_req_addr, 32'h800);
        chk("R9 held len", rd_req_len, 8);
        step(1);
        fifo_level = LW'(30);
        step(2);
        @(negedge clk);
        chk("R10 reached", fill_ok, 1);
        rd_req_ready = 1'b1;
        step(20);
        @(negedge clk);
        chk("R8 no room count", n_req, 1);
        chk("R8 no room valid", rd_req_valid, 0);
        step(1);
        fifo_level = LW'(10);
        step(10);
        chk("R8 room again", log_addr[1], 32'h820);
        run_en = 1'b0; fifo_level = '0;
        for (int i = 0; i < 300 && n_stop < 1; i++) step(1);
        chk("R7 stop after stall", n_stop, 1);
        step(3);
        @(negedge clk);
        chk("R10 cleared idle", fill_ok, 0);
    endtask

    task automatic t_bad_code();
        burst_sel = 3'd5;
        clear_stats();
        run_en = 1'b1;
        step(30);
        @(negedge clk);
        chk("R3 bad flag", bad_burst_cfg, 1);
        chk("R3 no requests", n_req, 0);
        run_en = 1'b0; burst_sel = 3'd2;
        step(2);
        @(negedge clk);
        chk("R3 flag clears", bad_burst_cfg, 0);
    endtask

    task automatic t_table();
        write_win(32'h200, 32'h2FFF);
        table_mode = 1'b1; burst_sel = 3'd1;
        clear_stats();
        run_en = 1'b1;
        step(100);
        chk("R6 count", n_req, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R6 addr", log_addr[i], 32'h200 + 8 * i);
            chk("R6 len", log_len[i], 2);
        end
        chk("R6 done", n_tab, 1);
        chk("R6 no frame end", n_end, 0);
        run_en = 1'b0; table_mode = 1'b0;
        step(3);
    endtask

    task automatic t_underrun();
        clear_stats();
        fifo_level = '0; pix_pull = 1'b1;
        step(1);
        pix_pull = 1'b0;
        step(3);
        chk("R11 one pulse", n_und, 1);
        fifo_level = LW'(3); pix_pull = 1'b1;
        step(5);
        pix_pull = 1'b0;
        step(2);
        chk("R11 not empty", n_und, 1);
    endtask

    initial begin
        t_reset();
        t_data_walk();
        t_stall_room();
        t_bad_code();
        t_table();
        t_underrun();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule